// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block runs the digital side of output-driver and termination impedance calibration. It places a 5-bit tuning code on a replica leg and reads one comparator bit. The comparator bit reports whether the replica node sits above half the supply. The search runs in two stages. In the first stage the block tunes the pull-up leg alone. In the second stage it keeps the settled pull-up result on a replica pull-up leg and tunes the pull-down leg against it. Each code bit is set by a binary search from the most significant bit down. Each decision is a majority vote over several comparator samples, so one noisy sample does not change the result.

The two finished codes stay in the block. They are copied to the driver legs only in a cycle when the data bus reports no transfer. Three event inputs start a calibration: system reset, DLL reset and a large phase jump. The block also starts one calibration by itself when it leaves reset. An event that arrives while a calibration is running is held as pending and starts one more calibration after the current one completes.

Top module: `imp_cal_seq`

## Requirements
- R1: While reset is asserted, and for two clock edges after its release, the following outputs are all 0: busy, done, both driver codes, both replica enables and both replica codes. The third edge after release starts a calibration with no event input.
- R2: When the block is idle, a one-cycle pulse on any event input (system, DLL or phase) sets busy_o two edges after the edge that samples the pulse.
- R3: In the pull-up stage, rep_up_en_o is 1 and rep_dn_en_o is 0, and rep_dn_code_o is 0. rep_up_code_o starts at 5'b10000. When the filtered comparator is 1 (node above half supply), the bit under trial is cleared; otherwise it is kept. The next lower bit is then set for its trial.
- R4: In the pull-down stage, both enables are 1 and rep_up_code_o holds the stored pull-up result without change. rep_dn_code_o follows the same 10000-first search, but with the opposite polarity: a filtered 1 keeps the bit and a filtered 0 clears it.
- R5: Each bit trial lasts SETTLE_CYC cycles with no sampling, followed by NSAMP sampling cycles (defaults 2 and 3). The bit decision uses the majority of the NSAMP samples. A single inverted sample in a window does not change the result.
- R6: If the comparator changes state at code threshold T, each stage ends after 5 trials with the code equal to T. In the pull-up stage, T is the largest code whose node is not above half. In the pull-down stage, T is the largest code whose node is still above half.
- R7: When both codes are settled, busy_o stays 1 and the driver codes stay unchanged for as long as bus_busy_i is 1. The first edge that samples bus_busy_i as 0 copies both codes to the driver outputs, sets done_o and clears busy_o.
- R8: Event pulses that arrive during a calibration, however many there are, cause exactly one further calibration. That calibration starts on the edge after busy_o falls.
- R9: done_o clears on the edge on which a new calibration starts. busy_o and done_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_sys_i | input | 1 | System reset event pulse |
| evt_dll_i | input | 1 | DLL reset event pulse |
| evt_phase_i | input | 1 | Large phase-shift event pulse |
| cmp_hi_i | input | 1 | Comparator: 1 when the replica node is above half supply |
| bus_busy_i | input | 1 | 1 while a data bus transfer is in progress |
| rep_up_en_o | output | 1 | Enable for the replica pull-up leg |
| rep_dn_en_o | output | 1 | Enable for the replica pull-down leg |
| rep_up_code_o | output | CODE_W | Code on the replica pull-up leg |
| rep_dn_code_o | output | CODE_W | Code on the replica pull-down leg |
| drv_up_code_o | output | CODE_W | Code applied to all driver pull-up legs |
| drv_dn_code_o | output | CODE_W | Code applied to all driver pull-down legs |
| busy_o | output | 1 | Calibration in progress, including the wait for an idle bus |
| done_o | output | 1 | Fresh codes have been applied since the last start |

## Verification
The assertions assume that the comparator is a monotonic function of the replica codes during sampling. They also assume that event inputs are single-cycle pulses and that bus_busy_i is a plain level. The bench drives all inputs on the falling edge. It derives the comparator from threshold values that it changes only between calibrations, and it adds noise by inverting exactly one sample in every 3-cycle window. A pull-down threshold that depends on the replica pull-up code shows that the stored pull-up result is really applied in the second stage.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SETTLE = 2'd1,
    CAL_SAMPLE = 2'd2,
    CAL_APPLY  = 2'd3
  } cal_state_e;

  typedef enum logic {
    LEG_UP = 1'b0,
    LEG_DN = 1'b1
  } cal_leg_e;
endpackage

// File: rtl/imp_cal_rstsync.sv
module imp_cal_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_q = hold_q;
endmodule

// File: rtl/imp_cal_trig.sv
module imp_cal_trig #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            take_i,
  output logic            pend_o
);
  logic pend_q;
  logic pend_d;

  // a pending request is consumed by take_i; a new event in the same cycle survives
  always_comb begin
    pend_d = (pend_q & ~take_i) | (|evt_i);
  end

  // reset leaves one request pending: the reset itself asks for a calibration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/imp_cal_vote.sv
module imp_cal_vote #(
  parameter int NSAMP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_i,
  input  logic cmp_i,
  output logic vote_o
);
  localparam int CW = $clog2(NSAMP + 1);

  logic [CW-1:0] ones_q;
  logic [CW-1:0] ones_d;
  logic [CW:0]   ones_w;

  // ones counted so far plus the sample presented in this cycle
  always_comb begin
    ones_w = {1'b0, ones_q} + {{CW{1'b0}}, cmp_i};
    vote_o = (2 * int'(ones_w)) > NSAMP;
  end

  always_comb begin
    ones_d = ones_q;
    if (clr_i)      ones_d = '0;
    else if (smp_i) ones_d = ones_w[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end
endmodule

// File: rtl/imp_cal_sar.sv
module imp_cal_sar #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         keep_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] code_nxt_o,
  output logic         last_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  code_q;
  logic [W-1:0]  code_d;
  logic [W-1:0]  code_res;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;

  // the trial code with the bit under test resolved
  always_comb begin
    code_res        = code_q;
    code_res[idx_q] = keep_i;
  end

  always_comb begin
    code_d = code_q;
    idx_d  = idx_q;
    if (load_i) begin
      code_d = {1'b1, {(W-1){1'b0}}};
      idx_d  = IW'(W - 1);
    end else if (step_i) begin
      code_d = code_res;
      if (idx_q != '0) begin
        idx_d                  = idx_q - 1'b1;
        code_d[idx_q - 1'b1]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
    end else begin
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign code_o     = code_q;
  assign code_nxt_o = code_res;
  assign last_o     = (idx_q == '0);
endmodule

// File: rtl/imp_cal_seq.sv
module imp_cal_seq
  import imp_cal_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int NSAMP      = 3,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_sys_i,
  input  logic              evt_dll_i,
  input  logic              evt_phase_i,
  input  logic              cmp_hi_i,
  input  logic              bus_busy_i,
  output logic              rep_up_en_o,
  output logic              rep_dn_en_o,
  output logic [CODE_W-1:0] rep_up_code_o,
  output logic [CODE_W-1:0] rep_dn_code_o,
  output logic [CODE_W-1:0] drv_up_code_o,
  output logic [CODE_W-1:0] drv_dn_code_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_MAX = (NSAMP > SETTLE_CYC) ? NSAMP : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int NEVT    = 3;

  logic rst_q;

  cal_state_e        state_q, state_d;
  cal_leg_e          leg_q, leg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] up_q, up_d;
  logic [CODE_W-1:0] dn_q, dn_d;
  logic [CODE_W-1:0] drv_up_q, drv_up_d;
  logic [CODE_W-1:0] drv_dn_q, drv_dn_d;
  logic              done_q, done_d;

  logic              pend;
  logic              take;
  logic              sar_load;
  logic              sar_step;
  logic              sar_keep;
  logic              sar_last;
  logic [CODE_W-1:0] sar_code;
  logic [CODE_W-1:0] sar_nxt;
  logic              v_clr;
  logic              v_smp;
  logic              vote;
  logic              searching;

  imp_cal_rstsync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  imp_cal_trig #(.NSRC(NEVT)) u_trig (
    .clk    (clk),
    .rst_n  (rst_q),
    .evt_i  ({evt_phase_i, evt_dll_i, evt_sys_i}),
    .take_i (take),
    .pend_o (pend)
  );

  imp_cal_vote #(.NSAMP(NSAMP)) u_vote (
    .clk    (clk),
    .rst_n  (rst_q),
    .clr_i  (v_clr),
    .smp_i  (v_smp),
    .cmp_i  (cmp_hi_i),
    .vote_o (vote)
  );

  imp_cal_sar #(.W(CODE_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_q),
    .load_i     (sar_load),
    .step_i     (sar_step),
    .keep_i     (sar_keep),
    .code_o     (sar_code),
    .code_nxt_o (sar_nxt),
    .last_o     (sar_last)
  );

  // node above half: pull-up too strong (clear) or pull-down too weak (keep)
  assign sar_keep = (leg_q == LEG_UP) ? ~vote : vote;

  always_comb begin
    state_d  = state_q;
    leg_d    = leg_q;
    cnt_d    = cnt_q;
    up_d     = up_q;
    dn_d     = dn_q;
    drv_up_d = drv_up_q;
    drv_dn_d = drv_dn_q;
    done_d   = done_q;
    take     = 1'b0;
    sar_load = 1'b0;
    sar_step = 1'b0;
    v_clr    = 1'b0;
    v_smp    = 1'b0;
    case (state_q)
      CAL_IDLE: begin
        if (pend) begin
          take     = 1'b1;
          sar_load = 1'b1;
          leg_d    = LEG_UP;
          cnt_d    = '0;
          done_d   = 1'b0;
          state_d  = CAL_SETTLE;
        end
      end
      CAL_SETTLE: begin
        v_clr = 1'b1;
        if (cnt_q == CNT_W'(SETTLE_CYC - 1)) begin
          cnt_d   = '0;
          state_d = CAL_SAMPLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CAL_SAMPLE: begin
        v_smp = 1'b1;
        if (cnt_q == CNT_W'(NSAMP - 1)) begin
          sar_step = 1'b1;
          cnt_d    = '0;
          state_d  = CAL_SETTLE;
          if (sar_last) begin
            if (leg_q == LEG_UP) begin
              up_d     = sar_nxt;
              leg_d    = LEG_DN;
              sar_load = 1'b1;
            end else begin
              dn_d    = sar_nxt;
              state_d = CAL_APPLY;
            end
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CAL_APPLY: begin
        if (!bus_busy_i) begin
          drv_up_d = up_q;
          drv_dn_d = dn_q;
          done_d   = 1'b1;
          state_d  = CAL_IDLE;
        end
      end
      default: state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= CAL_IDLE;
      leg_q    <= LEG_UP;
      cnt_q    <= '0;
      up_q     <= '0;
      dn_q     <= '0;
      drv_up_q <= '0;
      drv_dn_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      leg_q    <= leg_d;
      cnt_q    <= cnt_d;
      up_q     <= up_d;
      dn_q     <= dn_d;
      drv_up_q <= drv_up_d;
      drv_dn_q <= drv_dn_d;
      done_q   <= done_d;
    end
  end

  assign searching     = (state_q == CAL_SETTLE) || (state_q == CAL_SAMPLE);
  assign rep_up_en_o   = searching;
  assign rep_dn_en_o   = searching && (leg_q == LEG_DN);
  assign rep_up_code_o = !searching ? '0 : ((leg_q == LEG_UP) ? sar_code : up_q);
  assign rep_dn_code_o = (searching && (leg_q == LEG_DN)) ? sar_code : '0;
  assign drv_up_code_o = drv_up_q;
  assign drv_dn_code_o = drv_dn_q;
  assign busy_o        = (state_q != CAL_IDLE);
  assign done_o        = done_q;
endmodule

// File: rtl/imp_cal_chk.sv
module imp_cal_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_q,
  input logic              evt_any,
  input logic              bus_busy_i,
  input logic              rep_up_en_o,
  input logic              rep_dn_en_o,
  input logic [CODE_W-1:0] rep_up_code_o,
  input logic [CODE_W-1:0] rep_dn_code_o,
  input logic [CODE_W-1:0] drv_up_code_o,
  input logic [CODE_W-1:0] drv_dn_code_o,
  input logic              busy_o,
  input logic              done_o
);
  // R4
  dn_needs_up_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rep_dn_en_o |-> rep_up_en_o);

  // R4
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rep_dn_en_o && $past(rep_dn_en_o)) |-> $stable(rep_up_code_o));

  // R3
  dn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rep_up_en_o && !rep_dn_en_o) |-> (rep_dn_code_o == '0));

  // R7
  up_apply_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(drv_up_code_o) |-> !$past(bus_busy_i));

  // R7
  dn_apply_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(drv_dn_code_o) |-> !$past(bus_busy_i));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(done_o) |-> (!busy_o && !$past(bus_busy_i)));

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(busy_o && done_o));

  // R2
  evt_start_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!busy_o && evt_any) |=> ##1 busy_o);
endmodule

bind imp_cal_seq imp_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rst_q         (rst_q),
  .evt_any       (evt_sys_i | evt_dll_i | evt_phase_i),
  .bus_busy_i    (bus_busy_i),
  .rep_up_en_o   (rep_up_en_o),
  .rep_dn_en_o   (rep_dn_en_o),
  .rep_up_code_o (rep_up_code_o),
  .rep_dn_code_o (rep_dn_code_o),
  .drv_up_code_o (drv_up_code_o),
  .drv_dn_code_o (drv_dn_code_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/tb_imp_cal_seq.sv
module tb_imp_cal_seq;
  localparam int W  = 5;
  localparam int NS = 3;
  localparam int ST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_sys = 1'b0, evt_dll = 1'b0, evt_ph = 1'b0;
  logic bus_busy = 1'b0;
  logic glitch = 1'b0;
  logic glitch_mode = 1'b0;
  int   tpu = 20, tpd = 9;
  int   cyc = 0;
  int   n_vec = 0, n_bad = 0;
  bit   finished = 1'b0;

  logic         rep_up_en, rep_dn_en, busy, done, cmp;
  logic [W-1:0] rep_up_code, rep_dn_code, drv_up_code, drv_dn_code;
  int           tpd_eff;

  always #10 clk = ~clk;

  assign tpd_eff = (tpd + int'(rep_up_code) / 8 > 31) ? 31 : tpd + int'(rep_up_code) / 8;
  assign cmp = (rep_dn_en ? (int'(rep_dn_code) <= tpd_eff) : (int'(rep_up_code) > tpu)) ^ glitch;

  imp_cal_seq dut (
    .clk(clk), .rst_n(rst_n),
    .evt_sys_i(evt_sys), .evt_dll_i(evt_dll), .evt_phase_i(evt_ph),
    .cmp_hi_i(cmp), .bus_busy_i(bus_busy),
    .rep_up_en_o(rep_up_en), .rep_dn_en_o(rep_dn_en),
    .rep_up_code_o(rep_up_code), .rep_dn_code_o(rep_dn_code),
    .drv_up_code_o(drv_up_code), .drv_dn_code_o(drv_dn_code),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0, m_leg = 0, m_code = 0, m_bit = 0, m_cnt = 0, m_ones = 0;
  int m_up = 0, m_dn = 0, m_dup = 0, m_ddn = 0, m_done = 0, m_pend = 1, m_rs = 0;

  function automatic int e_search();
    return (m_st == 1 || m_st == 2) ? 1 : 0;
  endfunction
  function automatic int e_rup();
    if (e_search() == 0) return 0;
    return (m_leg == 1) ? m_up : m_code;
  endfunction
  function automatic int e_rdn();
    return (e_search() == 1 && m_leg == 1) ? m_code : 0;
  endfunction

  task automatic m_reset();
    m_st = 0; m_leg = 0; m_code = 0; m_bit = 0; m_cnt = 0; m_ones = 0;
    m_up = 0; m_dn = 0; m_dup = 0; m_ddn = 0; m_done = 0; m_pend = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_reset(); m_rs = 0;
    end else if (m_rs < 2) begin
      m_reset(); m_rs++;
    end else begin
      int eff, take, c, vote, keep;
      eff  = (tpd + e_rup() / 8 > 31) ? 31 : tpd + e_rup() / 8;
      c    = ((e_search() == 1 && m_leg == 1) ? (e_rdn() <= eff) : (e_rup() > tpu)) ? 1 : 0;
      c    = c ^ int'(glitch);
      take = 0;
      case (m_st)
        0: if (m_pend == 1) begin
             take = 1; m_st = 1; m_leg = 0; m_code = 16; m_bit = 4; m_cnt = 0; m_done = 0;
           end
        1: if (m_cnt == ST - 1) begin m_cnt = 0; m_st = 2; m_ones = 0; end
           else m_cnt++;
        2: begin
             m_ones += c;
             if (m_cnt == NS - 1) begin
               vote = (2 * m_ones > NS) ? 1 : 0;
               keep = (m_leg == 0) ? 1 - vote : vote;
               if (keep == 0) m_code = m_code & ~(1 << m_bit);
               m_cnt = 0; m_st = 1;
               if (m_bit == 0) begin
                 if (m_leg == 0) begin m_up = m_code; m_leg = 1; m_code = 16; m_bit = 4; end
                 else begin m_dn = m_code; m_st = 3; end
               end else begin
                 m_bit--; m_code = m_code | (1 << m_bit);
               end
             end else m_cnt++;
           end
        default: if (!bus_busy) begin
             m_dup = m_up; m_ddn = m_dn; m_done = 1; m_st = 0;
           end
      endcase
      m_pend = ((m_pend == 1 && take == 0) || (evt_sys | evt_dll | evt_ph)) ? 1 : 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk("R9", "busy", int'(busy), (m_st != 0) ? 1 : 0);
      chk("R9", "done", int'(done), m_done);
      chk("R3", "rep_up_en", int'(rep_up_en), e_search());
      chk("R4", "rep_dn_en", int'(rep_dn_en), (e_search() == 1 && m_leg == 1) ? 1 : 0);
      chk("R3", "rep_up_code", int'(rep_up_code), e_rup());
      chk("R4", "rep_dn_code", int'(rep_dn_code), e_rdn());
      chk("R7", "drv_up_code", int'(drv_up_code), m_dup);
      chk("R7", "drv_dn_code", int'(drv_dn_code), m_ddn);
    end
  end

  // one inverted comparator sample in every 3-cycle window when enabled
  always @(negedge clk) glitch <= glitch_mode && (cyc % 3 == 0);

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired, run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy !== 1'b0) @(negedge clk);
  endtask

  function automatic int exp_dn();
    return (tpd + tpu / 8 > 31) ? 31 : tpd + tpu / 8;
  endfunction

  task automatic pulse(input int which);
    if (which == 0) evt_sys = 1'b1;
    else if (which == 1) evt_dll = 1'b1;
    else evt_ph = 1'b1;
    @(negedge clk);
    evt_sys = 1'b0; evt_dll = 1'b0; evt_ph = 1'b0;
  endtask

  initial begin
    // R1: reset state
    nclk(3);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "drv_up in reset", int'(drv_up_code), 0);
    chk("R1", "rep_up_en in reset", int'(rep_up_en), 0);
    rst_n = 1'b1;
    nclk(2);
    chk("R1", "busy after two edges", int'(busy), 0);
    nclk(1);
    chk("R1", "auto start busy", int'(busy), 1);
    chk("R3", "first pull-up trial", int'(rep_up_code), 16);
    chk("R3", "pull-down leg off", int'(rep_dn_en), 0);
    while (rep_dn_en !== 1'b1) @(negedge clk);
    chk("R4", "stored pull-up held", int'(rep_up_code), tpu);
    chk("R4", "first pull-down trial", int'(rep_dn_code), 16);
    wait_idle();
    chk("R6", "pull-up result", int'(drv_up_code), tpu);
    chk("R6", "pull-down result", int'(drv_dn_code), exp_dn());
    chk("R9", "done after apply", int'(done), 1);

    // R2 and boundary codes 0
    tpu = 0; tpd = 0;
    nclk(3);
    pulse(0);
    chk("R2", "busy one edge after sample", int'(busy), 0);
    nclk(1);
    chk("R2", "busy two edges after sample", int'(busy), 1);
    chk("R9", "done cleared on start", int'(done), 0);
    wait_idle();
    chk("R6", "pull-up result zero", int'(drv_up_code), 0);
    chk("R6", "pull-down result zero", int'(drv_dn_code), 0);

    // R5 noisy comparator, R7 bus deferral, boundary codes 31
    tpu = 31; tpd = 31;
    glitch_mode = 1'b1;
    nclk(2);
    pulse(1);
    bus_busy = 1'b1;
    nclk(2);
    while (rep_up_en !== 1'b0) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R7", "held while bus busy", int'(drv_up_code), 0);
      chk("R7", "busy while waiting", int'(busy), 1);
      @(negedge clk);
    end
    bus_busy = 1'b0;
    @(negedge clk);
    chk("R7", "applied once bus idle", int'(drv_up_code), 31);
    chk("R5", "pull-down with noise", int'(drv_dn_code), 31);
    chk("R7", "done on apply", int'(done), 1);
    glitch_mode = 1'b0;

    // R8 triggers during a calibration collapse to one rerun
    tpu = 13; tpd = 4;
    pulse(2);
    nclk(10);
    pulse(1);
    nclk(5);
    pulse(0);
    wait_idle();
    chk("R6", "pull-up mid code", int'(drv_up_code), 13);
    @(negedge clk);
    chk("R8", "rerun starts", int'(busy), 1);
    wait_idle();
    nclk(10);
    chk("R8", "only one rerun", int'(busy), 0);
    chk("R6", "pull-down mid code", int'(drv_dn_code), exp_dn());

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule